// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits in front of a single-ported word memory that several requesters share. Each requester can issue a plain load, a plain store, a load-linked or a store-conditional. A load-linked returns the addressed word and arms a reservation for that requester on that address. A later store-conditional from the same requester writes memory only if the reservation is still intact. It reports a pass or fail flag, so that software can retry its whole read-modify-write sequence.

Every requester has exactly one reservation, made of a valid bit and an address. The reservation is dropped for several reasons: another write lands on the reserved word, a line-replacement notice names that word, a context switch is signalled for that requester, or the requester issues a store-conditional. A fixed-priority arbiter serves one request per cycle. The grant and the response both appear one cycle after the request is accepted.

Top module: `llsc_monitor`

## Requirements
- R1: Operation codes are 0 load, 1 store, 2 load-linked, 3 store-conditional. A request accepted at a clock edge yields, in the following cycle, a one-hot `grantValid` bit for that requester, `rspValid`=1, `rspId`=requester index, and `rspData` equal to the addressed word as it was before any write of that edge. After reset, memory reads as zero, no grant or response is raised, and no reservation is valid.
- R2: A load-linked returns the addressed word and records a valid reservation on that address for the issuing requester.
- R3: A store-conditional whose requester holds a valid reservation on the same address writes its data and returns `rspScOk`=1.
- R4: A store-conditional with no valid reservation, or with an address different from the reserved one, returns `rspScOk`=0 and leaves memory unchanged.
- R5: Any committed write (a plain store or a successful store-conditional) cancels every reservation held on that address. Reservations on other addresses survive.
- R6: `evictValid` with `evictAddr` equal to a reservation's address cancels that reservation. A different address leaves it intact.
- R7: `ctxSwitch[i]` cancels the reservation of requester i only.
- R8: Every store-conditional, whether it passes or fails, clears the issuing requester's reservation.
- R9: A new load-linked replaces the requester's previous reservation.
- R10: Among simultaneous requests, the lowest index is granted. Exactly one request is served per cycle, and the others wait until they are granted.
- R11: A context switch or a matching replacement notice in the same cycle as a store-conditional makes it fail without writing. The same events in the same cycle as a load-linked leave no reservation.
- R12: A plain store always writes its data, and `rspScOk` is 0 for all operations other than a passing store-conditional.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | NUM_REQ | Request pending, one bit per requester |
| reqOp | input | 2*NUM_REQ | Operation code per requester |
| reqAddr | input | ADDR_W*NUM_REQ | Word address per requester |
| reqWdata | input | DATA_W*NUM_REQ | Store data per requester |
| evictValid | input | 1 | Line-replacement notice |
| evictAddr | input | ADDR_W | Address being replaced |
| ctxSwitch | input | NUM_REQ | Context switch per requester |
| grantValid | output | NUM_REQ | One-hot grant, one cycle after acceptance |
| rspValid | output | 1 | Response present |
| rspId | output | ID_W | Index of the served requester |
| rspData | output | DATA_W | Word read before the write |
| rspScOk | output | 1 | Store-conditional passed |

## Verification
The block's hard corner is a store-conditional that meets a cancelling event in the same cycle: a context switch for the issuer, or a replacement notice on the reserved address. The bench first arms a reservation, then drives the cancelling input on the same edge at which the store-conditional is accepted. It judges the pass flag and the word read back afterwards. The same coincidence is applied to a load-linked, and a follow-up store-conditional must then fail. Address sweeps over every requester and every word cover the plain paths, with expected words computed from the sweep index.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_LL    = 2'd2,
    OP_SC    = 2'd3
  } memOp_e;

  // Strobes handed from the control to the datapath each cycle.
  typedef struct packed {
    logic fire;    // a request was accepted this cycle
    logic memWe;   // commit the write at this edge
    logic scOk;    // store-conditional passes
  } strobe_t;
endpackage

// File: rtl/llsc_ctrl.sv
module llsc_ctrl
  import llsc_pkg::*;
#(
  parameter int NUM_REQ = 3,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 8,
  localparam int ID_W   = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_REQ-1:0]         reqValid,
  input  logic [2*NUM_REQ-1:0]       reqOp,
  input  logic [ADDR_W*NUM_REQ-1:0]  reqAddr,
  input  logic [DATA_W*NUM_REQ-1:0]  reqWdata,
  input  logic                       evictValid,
  input  logic [ADDR_W-1:0]          evictAddr,
  input  logic [NUM_REQ-1:0]         ctxSwitch,
  output strobe_t                    strb,
  output logic [NUM_REQ-1:0]         grantVec,
  output logic [ID_W-1:0]            gId,
  output logic [ADDR_W-1:0]          gAddr,
  output logic [DATA_W-1:0]          gWdata
);
  memOp_e             gOp;
  logic [NUM_REQ-1:0] resvValid;
  logic [ADDR_W-1:0]  resvAddr [NUM_REQ];
  logic               resvHit;
  logic               cancelNow;

  // Fixed priority: lowest index wins (loop runs downward, last hit sticks).
  always_comb begin
    grantVec = '0;
    gId      = '0;
    gOp      = OP_LOAD;
    gAddr    = '0;
    gWdata   = '0;
    for (int i = NUM_REQ - 1; i >= 0; i--) begin
      if (reqValid[i]) begin
        grantVec = '0;
        grantVec[i] = 1'b1;
        gId    = ID_W'(i);
        gOp    = memOp_e'(reqOp[i*2 +: 2]);
        gAddr  = reqAddr[i*ADDR_W +: ADDR_W];
        gWdata = reqWdata[i*DATA_W +: DATA_W];
      end
    end
  end

  always_comb begin
    resvHit   = |(grantVec & resvValid) && (resvAddr[gId] == gAddr);
    cancelNow = |(grantVec & ctxSwitch) || (evictValid && evictAddr == gAddr);
    strb.fire  = |reqValid;
    strb.scOk  = strb.fire && (gOp == OP_SC) && resvHit && !cancelNow;
    strb.memWe = strb.fire && ((gOp == OP_STORE) || strb.scOk);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resvValid <= '0;
      for (int j = 0; j < NUM_REQ; j++) resvAddr[j] <= '0;
    end else begin
      for (int j = 0; j < NUM_REQ; j++) begin
        logic llNow;
        logic [ADDR_W-1:0] watchAddr;
        llNow     = strb.fire && grantVec[j] && (gOp == OP_LL);
        watchAddr = llNow ? gAddr : resvAddr[j];
        if (llNow) begin
          resvValid[j] <= 1'b1;
          resvAddr[j]  <= gAddr;
        end else if (strb.fire && grantVec[j] && gOp == OP_SC) begin
          resvValid[j] <= 1'b0;
        end
        if (strb.memWe && !llNow && gAddr == resvAddr[j]) resvValid[j] <= 1'b0;
        if (evictValid && evictAddr == watchAddr)         resvValid[j] <= 1'b0;
        if (ctxSwitch[j])                                  resvValid[j] <= 1'b0;
      end
    end
  end

  p_sc_fail_nowrite_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.fire && gOp == OP_SC && !resvHit) |-> !strb.memWe);

  for (genvar j = 0; j < NUM_REQ; j++) begin : g_chk
    p_ll_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (strb.fire && grantVec[j] && gOp == OP_LL && !ctxSwitch[j] &&
       !(evictValid && evictAddr == gAddr))
      |=> (resvValid[j] && resvAddr[j] == $past(gAddr)));
    p_write_cancel_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (strb.memWe && resvValid[j] && resvAddr[j] == gAddr) |=> !resvValid[j]);
    p_evict_cancel_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (evictValid && resvValid[j] && evictAddr == resvAddr[j] &&
       !(strb.fire && grantVec[j] && gOp == OP_LL)) |=> !resvValid[j]);
    p_ctx_cancel_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ctxSwitch[j] |=> !resvValid[j]);
    p_sc_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (strb.fire && grantVec[j] && gOp == OP_SC) |=> !resvValid[j]);
  end
endmodule

// File: rtl/llsc_data.sv
module llsc_data
  import llsc_pkg::*;
#(
  parameter int NUM_REQ = 3,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 8,
  localparam int ID_W   = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  strobe_t            strb,
  input  logic [NUM_REQ-1:0] grantVec,
  input  logic [ID_W-1:0]    gId,
  input  logic [ADDR_W-1:0]  gAddr,
  input  logic [DATA_W-1:0]  gWdata,
  output logic [NUM_REQ-1:0] grantValid,
  output logic               rspValid,
  output logic [ID_W-1:0]    rspId,
  output logic [DATA_W-1:0]  rspData,
  output logic               rspScOk
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
    end else if (strb.memWe) begin
      mem[gAddr] <= gWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grantValid <= '0;
      rspValid   <= 1'b0;
      rspId      <= '0;
      rspData    <= '0;
      rspScOk    <= 1'b0;
    end else begin
      grantValid <= strb.fire ? grantVec : '0;
      rspValid   <= strb.fire;
      rspId      <= gId;
      rspData    <= mem[gAddr];
      rspScOk    <= strb.scOk;
    end
  end

  p_grant_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grantValid));
  p_rsp_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    strb.fire |=> rspValid);
  p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    strb.memWe |=> (mem[$past(gAddr)] == $past(gWdata)));
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int NUM_REQ = 3,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 8,
  localparam int ID_W   = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_REQ-1:0]        reqValid,
  input  logic [2*NUM_REQ-1:0]      reqOp,
  input  logic [ADDR_W*NUM_REQ-1:0] reqAddr,
  input  logic [DATA_W*NUM_REQ-1:0] reqWdata,
  input  logic                      evictValid,
  input  logic [ADDR_W-1:0]         evictAddr,
  input  logic [NUM_REQ-1:0]        ctxSwitch,
  output logic [NUM_REQ-1:0]        grantValid,
  output logic                      rspValid,
  output logic [ID_W-1:0]           rspId,
  output logic [DATA_W-1:0]         rspData,
  output logic                      rspScOk
);
  strobe_t            strb;
  logic [NUM_REQ-1:0] grantVec;
  logic [ID_W-1:0]    gId;
  logic [ADDR_W-1:0]  gAddr;
  logic [DATA_W-1:0]  gWdata;

  llsc_ctrl #(.NUM_REQ(NUM_REQ), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .evictValid(evictValid),
    .evictAddr(evictAddr), .ctxSwitch(ctxSwitch), .strb(strb),
    .grantVec(grantVec), .gId(gId), .gAddr(gAddr), .gWdata(gWdata));

  llsc_data #(.NUM_REQ(NUM_REQ), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) data_i (
    .clk(clk), .rst_n(rst_n), .strb(strb), .grantVec(grantVec), .gId(gId),
    .gAddr(gAddr), .gWdata(gWdata), .grantValid(grantValid),
    .rspValid(rspValid), .rspId(rspId), .rspData(rspData), .rspScOk(rspScOk));
endmodule

// File: tb/llsc_monitor_tb_top.sv
module llsc_monitor_tb_top;
  localparam int NR = 3;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int IW = 2;
  localparam int LOAD = 0, STORE = 1, LL = 2, SC = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NR-1:0]    reqValid = '0;
  logic [2*NR-1:0]  reqOp = '0;
  logic [AW*NR-1:0] reqAddr = '0;
  logic [DW*NR-1:0] reqWdata = '0;
  logic             evictValid = 1'b0;
  logic [AW-1:0]    evictAddr = '0;
  logic [NR-1:0]    ctxSwitch = '0;
  logic [NR-1:0]    grantValid;
  logic             rspValid;
  logic [IW-1:0]    rspId;
  logic [DW-1:0]    rspData;
  logic             rspScOk;

  int nChecks = 0;
  int nFail = 0;
  int expMem [16];

  always #10 clk = ~clk;

  llsc_monitor #(.NUM_REQ(NR), .ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .evictValid(evictValid),
    .evictAddr(evictAddr), .ctxSwitch(ctxSwitch), .grantValid(grantValid),
    .rspValid(rspValid), .rspId(rspId), .rspData(rspData), .rspScOk(rspScOk));

  task automatic check(string tag, int got, int exp);
    nChecks++;
    if (got != exp) begin
      nFail++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  // One request, with optional same-cycle context switch / replacement.
  task automatic doOp(int id, int op, int addr, int wd, int ctxMask = 0,
                      bit evEn = 0, int evA = 0);
    @(negedge clk);
    reqValid = '0;
    reqValid[id] = 1'b1;
    reqOp[id*2 +: 2] = op[1:0];
    reqAddr[id*AW +: AW] = addr[AW-1:0];
    reqWdata[id*DW +: DW] = wd[DW-1:0];
    ctxSwitch = ctxMask[NR-1:0];
    evictValid = evEn;
    evictAddr = evA[AW-1:0];
    @(negedge clk);
    reqValid = '0;
    ctxSwitch = '0;
    evictValid = 1'b0;
    check("R1 grant", int'(grantValid), 1 << id);
    check("R1 rspId", int'(rspId), id);
    check("R1 rspValid", int'(rspValid), 1);
  endtask

  task automatic pulseEvent(int ctxMask, bit evEn, int evA);
    @(negedge clk);
    ctxSwitch = ctxMask[NR-1:0];
    evictValid = evEn;
    evictAddr = evA[AW-1:0];
    @(negedge clk);
    ctxSwitch = '0;
    evictValid = 1'b0;
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    for (int k = 0; k < 16; k++) expMem[k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset grant", int'(grantValid), 0);
    check("R1 reset rspValid", int'(rspValid), 0);

    // R4: no reservation after reset
    doOp(0, SC, 4, 99);
    check("R4 sc after reset ok", int'(rspScOk), 0);
    doOp(1, LOAD, 4, 0);
    check("R4 sc after reset mem", int'(rspData), 0);

    // R12/R1 sweep: stores then loads from another requester
    for (int a = 0; a < 16; a++) begin
      doOp(0, STORE, a, (a * 5 + 1) & 255);
      check("R1 store returns old word", int'(rspData), expMem[a]);
      check("R12 store scOk", int'(rspScOk), 0);
      expMem[a] = (a * 5 + 1) & 255;
    end
    for (int a = 0; a < 16; a++) begin
      doOp(1, LOAD, a, 0);
      check("R12 load after store", int'(rspData), expMem[a]);
    end

    // R2/R3/R8 sweep over every requester and address
    for (int i = 0; i < NR; i++) begin
      for (int a = 0; a < 16; a++) begin
        int v;
        v = (i * 16 + a * 3 + 7) & 255;
        doOp(i, LL, a, 0);
        check("R2 ll data", int'(rspData), expMem[a]);
        doOp(i, SC, a, v);
        check("R3 sc ok", int'(rspScOk), 1);
        expMem[a] = v;
        doOp(i, SC, a, v ^ 255);
        check("R8 second sc fails", int'(rspScOk), 0);
        check("R3 word written", int'(rspData), v);
      end
    end

    // R4: address mismatch
    doOp(0, LL, 2, 0);
    doOp(0, SC, 3, 77);
    check("R4 mismatch ok", int'(rspScOk), 0);
    doOp(1, LOAD, 3, 0);
    check("R4 mismatch mem", int'(rspData), expMem[3]);

    // R5: another requester's store
    doOp(0, LL, 5, 0);
    doOp(1, STORE, 5, 33); expMem[5] = 33;
    doOp(0, SC, 5, 44);
    check("R5 conflicting store cancels", int'(rspScOk), 0);
    doOp(0, LL, 5, 0);
    doOp(1, STORE, 6, 34); expMem[6] = 34;
    doOp(0, SC, 5, 45);
    check("R5 other address keeps", int'(rspScOk), 1);
    expMem[5] = 45;
    // R5: successful SC of one requester cancels another's reservation
    doOp(1, LL, 8, 0);
    doOp(2, LL, 8, 0);
    doOp(2, SC, 8, 90); expMem[8] = 90;
    check("R5 winner sc", int'(rspScOk), 1);
    doOp(1, SC, 8, 91);
    check("R5 loser sc", int'(rspScOk), 0);
    doOp(0, LOAD, 8, 0);
    check("R5 loser no write", int'(rspData), 90);

    // R6: replacement notice
    doOp(2, LL, 3, 0);
    pulseEvent(0, 1, 3);
    doOp(2, SC, 3, 12);
    check("R6 evict match cancels", int'(rspScOk), 0);
    doOp(2, LL, 3, 0);
    pulseEvent(0, 1, 4);
    doOp(2, SC, 3, 13); expMem[3] = 13;
    check("R6 evict other keeps", int'(rspScOk), 1);

    // R7: context switch
    doOp(1, LL, 10, 0);
    pulseEvent(3'b010, 0, 0);
    doOp(1, SC, 10, 21);
    check("R7 ctx cancels", int'(rspScOk), 0);
    doOp(1, LL, 10, 0);
    pulseEvent(3'b101, 0, 0);
    doOp(1, SC, 10, 22); expMem[10] = 22;
    check("R7 other ctx keeps", int'(rspScOk), 1);

    // R9: new LL replaces old
    doOp(0, LL, 2, 0);
    doOp(0, LL, 7, 0);
    doOp(0, SC, 2, 50);
    check("R9 old reservation gone", int'(rspScOk), 0);
    doOp(0, LL, 2, 0);
    doOp(0, LL, 7, 0);
    doOp(0, SC, 7, 51); expMem[7] = 51;
    check("R9 new reservation holds", int'(rspScOk), 1);

    // R11: same-cycle cancel with SC and with LL
    doOp(2, LL, 9, 0);
    doOp(2, SC, 9, 60, 3'b100);
    check("R11 ctx same cycle sc", int'(rspScOk), 0);
    doOp(2, LL, 9, 0);
    doOp(2, SC, 9, 61, 0, 1, 9);
    check("R11 evict same cycle sc", int'(rspScOk), 0);
    doOp(0, LOAD, 9, 0);
    check("R11 memory untouched", int'(rspData), expMem[9]);
    doOp(2, LL, 9, 0, 3'b100);
    doOp(2, SC, 9, 62);
    check("R11 ctx same cycle ll", int'(rspScOk), 0);
    doOp(2, LL, 9, 0, 0, 1, 9);
    doOp(2, SC, 9, 63);
    check("R11 evict same cycle ll", int'(rspScOk), 0);

    // R10: fixed priority among simultaneous loads
    @(negedge clk);
    for (int i = 0; i < NR; i++) begin
      reqOp[i*2 +: 2] = 2'(LOAD);
      reqAddr[i*AW +: AW] = AW'(i + 11);
    end
    reqValid = '1;
    for (int i = 0; i < NR; i++) begin
      @(negedge clk);
      check("R10 grant order", int'(grantValid), 1 << i);
      check("R10 rspId", int'(rspId), i);
      check("R10 data", int'(rspData), expMem[i + 11]);
      reqValid[i] = 1'b0;
    end
    @(negedge clk);
    check("R10 idle after drain", int'(rspValid), 0);

    finishRun();
  end
endmodule